// File: doc/BRIEF.md
# Per-CPU Timer Tick Thinning Counters

Four counters, one for each CPU, sit between a shared periodic timer tick and the CPUs' timer interrupts. Software loads a 24-bit count into a CPU's counter. Each rising edge of the tick input then decrements every counter whose CPU is marked present. The count runs down past zero into bit 24, a sticky overflow flag. From that point on, each tick raises a one-cycle timer set pulse for that CPU. The lower bits keep falling, so software can tell how many ticks passed since the interrupt first fired.

Registers are reached over a 32-bit port that carries 64-bit values in two halves. A write to the low half (address bit 2 clear) only stores the word in a staging register. The write to the high half (address bit 2 set) commits the staged word to the addressed register. A read of the low half returns the register and stages its upper 32 bits, which are always zero here. A read of the high half returns whatever the staging register holds.

Top module: `tick_skip_counter`

## Requirements
- R1: The counters of CPUs 0, 1, 2 and 3 live at byte offsets 0x380, 0x3C0, 0x700 and 0x740. A low-half write (address bit 2 clear) only stages the data word. A high-half write (offset+4) loads bits [23:0] of the staged word into the counter and clears bit 24. Staged bits above 23 are dropped.
- R2: On each tick rising edge, every present counter is replaced by its 25-bit value minus one, with bit 24 then ORed with its previous value. The new value is visible one clock after the edge is sampled.
- R3: After a counter updates on a tick and its bit 24 is set, `timer_set[i]` is high for exactly the one cycle in which that new value first appears.
- R4: A tick level held high for several cycles causes only one update, and a falling or low tick does nothing. A tick that is already high when reset is released is not treated as an edge.
- R5: A counter whose `present` bit is 0 neither changes nor pulses on a tick.
- R6: A low-half read of a counter returns its 25-bit value zero-extended and stages zero. A following high-half read returns the staged word, which is 0.
- R7: When a committing write and a tick edge reach the same counter in the same cycle, the written value is stored and that CPU gets no pulse.
- R8: Reset clears every counter to 0 with overflow clear. A low-half read of an unmapped offset returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| present | input | 4 | One bit per CPU; 1 marks the CPU as active |
| tick_lvl | input | 1 | Periodic timer tick level |
| csr_wr | input | 1 | Register write strobe, one cycle per half |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 12 | Byte offset; bit 2 selects the high half |
| csr_wdata | input | 32 | Write data half-word |
| csr_rdata | output | 32 | Read data, combinational from address |
| timer_set | output | 4 | One-cycle timer interrupt set pulse per CPU |

## Verification
The assertions assume that `csr_wr` and `csr_rd` are never high in the same cycle. They also assume that `present` is steady around a tick edge and that the tick input is low or stable while reset is active. The bench drives every strobe and the tick from the falling clock edge and issues one access at a time. It keeps `present` fixed for the whole of each sequence, and it raises the tick during reset only to check that a level which is already high at reset release is ignored.

// File: rtl/tick_skip_counter.sv
module tick_skip_counter #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        present,
  input  logic              tick_lvl,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic [3:0]        timer_set
);
  localparam int NCPU  = 4;
  localparam int VAL_W = CNT_W + 1;

  function automatic logic [ADDR_W-1:0] slot_addr(input int i);
    case (i)
      0:       slot_addr = ADDR_W'('h380);
      1:       slot_addr = ADDR_W'('h3C0);
      2:       slot_addr = ADDR_W'('h700);
      default: slot_addr = ADDR_W'('h740);
    endcase
  endfunction

  logic [DATA_W-1:0]           stage_q;
  logic [NCPU-1:0][VAL_W-1:0]  cnt_q;
  logic [NCPU-1:0][VAL_W-1:0]  dec_val;
  logic [NCPU-1:0]             hit;
  logic [NCPU-1:0]             wr_hit;
  logic                        tick_q;

  wire              tick_rise = tick_lvl & ~tick_q;
  wire              hi_half   = csr_addr[2];
  wire [ADDR_W-1:0] base      = {csr_addr[ADDR_W-1:3], 3'b000};
  wire              commit    = csr_wr & hi_half;

  for (genvar i = 0; i < NCPU; i++) begin : g_slot
    assign hit[i]     = (base == slot_addr(i));
    assign wr_hit[i]  = commit & hit[i];
    assign dec_val[i] = (cnt_q[i] - VAL_W'(1)) | {cnt_q[i][CNT_W], {CNT_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q    <= 1'b1;
      stage_q   <= '0;
      cnt_q     <= '0;
      timer_set <= '0;
    end else begin
      tick_q <= tick_lvl;
      if (csr_wr && !hi_half)
        stage_q <= csr_wdata;
      else if (csr_rd && !hi_half && (|hit))
        stage_q <= '0;
      for (int i = 0; i < NCPU; i++) begin
        timer_set[i] <= 1'b0;
        if (wr_hit[i])
          cnt_q[i] <= {1'b0, stage_q[CNT_W-1:0]};
        else if (tick_rise && present[i]) begin
          cnt_q[i]     <= dec_val[i];
          timer_set[i] <= dec_val[i][CNT_W];
        end
      end
    end
  end

  always_comb begin
    csr_rdata = '1;
    if (hi_half)
      csr_rdata = stage_q;
    else
      for (int i = 0; i < NCPU; i++)
        if (hit[i]) csr_rdata = DATA_W'(cnt_q[i]);
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_chk
    // R3: overflow never drops except through a committing write
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_q[i][CNT_W]) && !$past(wr_hit[i])) |-> cnt_q[i][CNT_W]);
    // R1: a committed write leaves the overflow bit clear
    a_r1_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> !cnt_q[i][CNT_W]);
    // R4 / R5: without an edge on a present CPU or a write, the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_rise && present[i]) && !wr_hit[i] |=> $stable(cnt_q[i]));
    // R5 / R7: a pulse needs a present CPU, an edge and no write
    a_r5_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      timer_set[i] |-> ($past(present[i]) && $past(tick_rise) && !$past(wr_hit[i])));
    // R3: a pulse only comes with the overflow bit set
    a_r3_pulse_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      timer_set[i] |-> cnt_q[i][CNT_W]);
  end

  // R4: one edge, then no further edge while the level stays high
  a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);
endmodule

// File: tb/tb_tick_skip_counter.sv
module tb_tick_skip_counter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  present = 4'hF;
  logic        tick_lvl = 0;
  logic        csr_wr = 0, csr_rd = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [3:0]  timer_set;

  tick_skip_counter dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int pc[4];
  localparam logic [11:0] BASE[4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

  always @(negedge clk)
    if (rst_n) for (int i = 0; i < 4; i++) if (timer_set[i]) pc[i]++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr64(logic [11:0] a, logic [31:0] lo);
    @(negedge clk); csr_wr = 1; csr_addr = a; csr_wdata = lo;
    @(negedge clk); csr_addr = a | 12'h4; csr_wdata = 32'h0;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic rd32(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); csr_rd = 1; csr_addr = a;
    #1 d = csr_rdata;
    @(negedge clk); csr_rd = 0;
  endtask

  task automatic tick();
    @(negedge clk); tick_lvl = 1;
    @(negedge clk); tick_lvl = 0;
    @(negedge clk);
  endtask

  function automatic logic [24:0] mdl(logic [23:0] v, int n, output int p);
    logic [24:0] c = {1'b0, v};
    p = 0;
    for (int k = 0; k < n; k++) begin
      c = ((c - 25'd1) & 25'h1FFFFFF) | (c & 25'h1000000);
      if (c[24]) p++;
    end
    return c;
  endfunction

  localparam int          NV = 7;
  localparam int          V_CPU[NV] = '{0, 1, 2, 3, 0, 3, 1};
  localparam logic [31:0] V_VAL[NV] = '{32'd5, 32'h10, 32'd2, 32'd0, 32'hFFFFFF, 32'd1, 32'hFF123456};
  localparam int          V_TIK[NV] = '{3, 4, 3, 2, 1, 4, 2};

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p, p0;
    logic [24:0] e;
    // R4: the tick is already high at reset release
    tick_lvl = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    tick_lvl = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd32(BASE[i], d); check("R8 reset value / R4 no edge at release", d, 0);
    end
    check("R4 no pulse from level at reset", pc[0] + pc[1] + pc[2] + pc[3], 0);
    rd32(12'h400, d); check("R8 unmapped read", d, 32'hFFFFFFFF);

    // R2 R3 R1: walk the vector table
    for (int v = 0; v < NV; v++) begin
      int c = V_CPU[v];
      wr64(BASE[c], V_VAL[v]);
      p0 = pc[c];
      for (int t = 0; t < V_TIK[v]; t++) tick();
      e = mdl(V_VAL[v][23:0], V_TIK[v], p);
      rd32(BASE[c], d); check("R2 count after ticks", d, {7'd0, e});
      check("R3 pulse count", pc[c] - p0, p);
    end

    // R1: a write clears the overflow that the table left on CPU 3
    wr64(BASE[3], 32'd9);
    rd32(BASE[3], d); check("R1 write clears overflow", d, 9);

    // R6: low read stages zero, high read returns it; a low write stages data
    @(negedge clk); csr_wr = 1; csr_addr = 12'h380; csr_wdata = 32'hDEADBEEF;
    @(negedge clk); csr_wr = 0;
    rd32(12'h384, d); check("R6 high read returns staged word", d, 32'hDEADBEEF);
    rd32(12'h380, d);
    rd32(12'h384, d); check("R6 staged upper half is zero", d, 0);

    // R4: a long high level decrements once
    wr64(BASE[2], 32'd10);
    @(negedge clk); tick_lvl = 1;
    repeat (5) @(negedge clk);
    tick_lvl = 0;
    repeat (2) @(negedge clk);
    rd32(BASE[2], d); check("R4 held level one decrement", d, 9);

    // R5: an absent CPU is untouched
    present = 4'b1101;
    wr64(BASE[1], 32'd0);
    wr64(BASE[0], 32'd4);
    p0 = pc[1];
    tick(); tick();
    rd32(BASE[1], d); check("R5 absent count unchanged", d, 0);
    check("R5 absent no pulse", pc[1] - p0, 0);
    rd32(BASE[0], d); check("R5 present still counts", d, 2);
    present = 4'hF;

    // R7: a write and a tick edge in the same cycle
    wr64(BASE[0], 32'd0);
    tick();
    rd32(BASE[0], d); check("R7 setup overflow", d, 32'h1FFFFFF);
    p0 = pc[0];
    @(negedge clk); csr_wr = 1; csr_addr = 12'h380; csr_wdata = 32'd7;
    @(negedge clk); csr_addr = 12'h384; csr_wdata = 0; tick_lvl = 1;
    @(negedge clk); csr_wr = 0;
    @(negedge clk); tick_lvl = 0;
    @(negedge clk);
    rd32(BASE[0], d); check("R7 write wins", d, 7);
    check("R7 no pulse on collision", pc[0] - p0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule